// File: doc/BRIEF.md
# Reset Qualification and Emulator-Mode Entry

This block turns the raw external reset pin into a clean internal reset and decides, each time that reset is released, whether the device comes up normally or in an emulator mode. In emulator mode an external tool drives the board. The reset pin is first brought into the oscillator clock domain through a flop chain. It then has to stay high across a set number of machine-cycle ticks before the internal reset asserts, so short spikes on the pin are ignored.

While the internal reset is held, the block watches two pin levels: the address-strobe pin and the program-fetch-strobe pin. It enters emulator mode only if two things are true. First, the address strobe was low and the fetch strobe was high on every cycle of the held reset. Second, the address strobe is still low on the first cycle after release. In emulator mode the block raises a float enable for the low port and a weak-pullup enable for the other pins and strobes. Only a later qualified reset, released without that pin pattern, brings the device back to normal operation. The oscillator clock and the machine-cycle tick keep running the whole time, so the block itself is never gated.

Top module: `rst_emu_ctrl`

## Requirements
- R1: While `arst_n` is low, and on the first cycles after it rises, `core_rst`, `emu_mode`, `p0_float_en` and `weak_pu_en` are all 0.
- R2: `rst_pin` passes through two synchronizing flops. `core_rst` rises on the clock edge at which the synchronized reset has been high for the second `mc_tick` pulse seen while it is high.
- R3: A high pulse on `rst_pin` whose synchronized copy spans fewer than two `mc_tick` pulses never asserts `core_rst`. Its partial count is cleared when the synchronized reset goes low, so separate short pulses do not add up.
- R4: `core_rst` falls on the first clock edge at which the synchronized reset is low, which is at most three clock cycles after `rst_pin` falls.
- R5: Emulator mode is entered on the first clock edge after `core_rst` falls, provided two conditions hold. `ale_pin` must have been 0 and `psen_pin` 1 on every cycle `core_rst` was 1. `ale_pin` must also be 0 on that first cycle after release.
- R6: If `ale_pin` is 1 on the last held-reset cycle or on the first cycle after release, the device comes out of reset in normal mode (`emu_mode` = 0).
- R7: A single cycle with `psen_pin` = 0 during the held reset prevents entry into emulator mode at that release.
- R8: `p0_float_en` and `weak_pu_en` are 1 exactly when `emu_mode` is 1.
- R9: Once in emulator mode, activity on `ale_pin` and `psen_pin` and unqualified `rst_pin` pulses leave `emu_mode` at 1. Only a qualified reset released without the entry pattern clears it.
- R10: `emu_mode` does not change while `core_rst` is 1. It changes only on the edge right after `core_rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| rst_pin | input | 1 | Raw external reset pin, active high |
| ale_pin | input | 1 | Sampled address-strobe pin level |
| psen_pin | input | 1 | Sampled program-fetch-strobe pin level |
| core_rst | output | 1 | Qualified internal reset |
| emu_mode | output | 1 | Emulator mode active |
| p0_float_en | output | 1 | Float the low port pins |
| weak_pu_en | output | 1 | Weak pull-up on the remaining pins and strobes |

## Verification
Reset is tried as pulses of three clocks, which never reach two ticks, and as long holds. This separates the qualifying counter from a plain level follower. Release is tried with the address strobe high, with it low and held, and with a one-cycle fetch-strobe glitch in the middle of reset. These cases show whether the block checks the pattern on every reset cycle and again at release, rather than only once. A long reset applied while already in emulator mode shows that the mode holds through reset and is decided again only at release.

// File: rtl/rstemu_pkg.sv
package rstemu_pkg;
  typedef enum logic {
    MODE_RUN = 1'b0,
    MODE_EMU = 1'b1
  } emu_mode_e;

  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned QUAL_TICKS_DEF = 2;
endpackage

// File: rtl/rstemu_sync.sv
module rstemu_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  assign stg_d[0] = d_in;
  generate
    for (genvar gi = 1; gi < STAGES; gi++) begin : g_chain
      assign stg_d[gi] = stg_q[gi-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q_out = stg_q[STAGES-1];

  // R2: the synchronized level is the pin level STAGES edges earlier
  p_sync_delay_r2: assert property (@(posedge clk) disable iff (!arst_n)
    q_out |-> $past(d_in, STAGES));
endmodule

// File: rtl/rstemu_qual.sv
module rstemu_qual #(
  parameter int unsigned QUAL_TICKS = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic rst_s,
  output logic held
);
  localparam int unsigned CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          held_q, held_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!rst_s)                     cnt_d = '0;
    else if (tick && cnt_q < LIMIT) cnt_d = cnt_q + 1'b1;
    held_d = (cnt_d == LIMIT);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
    end
  end

  assign held = held_q;

  // R2: reset only asserts while the synchronized pin was high
  p_held_needs_pin_r2: assert property (@(posedge clk) disable iff (!arst_n)
    held |-> $past(rst_s));
  // R2: assertion happens on a machine-cycle tick
  p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(held) |-> $past(tick));
  // R4: a low synchronized pin drops reset on the next edge
  p_drop_on_low_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_s |=> !held);
endmodule

// File: rtl/rstemu_entry.sv
module rstemu_entry
  import rstemu_pkg::*;
(
  input  logic      clk,
  input  logic      arst_n,
  input  logic      core_rst,
  input  logic      ale,
  input  logic      psen,
  output emu_mode_e mode
);
  logic      hprev_q, hprev_d;
  logic      armed_q, armed_d;
  emu_mode_e mode_q, mode_d;
  logic      pat_ok;
  logic      release_evt;

  assign pat_ok      = !ale && psen;
  assign release_evt = hprev_q && !core_rst;

  always_comb begin
    hprev_d = core_rst;
    armed_d = 1'b0;
    if (core_rst) armed_d = hprev_q ? (armed_q && pat_ok) : pat_ok;
    mode_d = mode_q;
    if (release_evt) mode_d = (armed_q && !ale) ? MODE_EMU : MODE_RUN;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hprev_q <= 1'b0;
      armed_q <= 1'b0;
      mode_q  <= MODE_RUN;
    end else begin
      hprev_q <= hprev_d;
      armed_q <= armed_d;
      mode_q  <= mode_d;
    end
  end

  assign mode = mode_q;

  // R10: mode only changes on the edge after reset falls
  p_mode_change_at_release_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_q != $past(mode_q)) |-> $past(hprev_q && !core_rst));
  // R10: mode is stable while reset is held
  p_mode_stable_in_reset_r10: assert property (@(posedge clk) disable iff (!arst_n)
    core_rst |=> $stable(mode_q));
  // R5: entry requires the address strobe low at release
  p_entry_ale_low_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_q == MODE_EMU && $past(mode_q) == MODE_RUN) |-> $past(!ale));
  // R7: entry requires the fetch strobe high on the last held cycle
  p_entry_psen_high_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_q == MODE_EMU && $past(mode_q) == MODE_RUN) |-> $past(psen, 2));
endmodule

// File: rtl/rst_emu_ctrl.sv
module rst_emu_ctrl
  import rstemu_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  parameter int unsigned QUAL_TICKS = QUAL_TICKS_DEF
) (
  input  logic clk,
  input  logic arst_n,
  input  logic mc_tick,
  input  logic rst_pin,
  input  logic ale_pin,
  input  logic psen_pin,
  output logic core_rst,
  output logic emu_mode,
  output logic p0_float_en,
  output logic weak_pu_en
);
  logic      rst_s;
  logic      held;
  emu_mode_e mode;

  rstemu_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d_in   (rst_pin),
    .q_out  (rst_s)
  );

  rstemu_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk    (clk),
    .arst_n (arst_n),
    .tick   (mc_tick),
    .rst_s  (rst_s),
    .held   (held)
  );

  rstemu_entry u_entry (
    .clk      (clk),
    .arst_n   (arst_n),
    .core_rst (held),
    .ale      (ale_pin),
    .psen     (psen_pin),
    .mode     (mode)
  );

  assign core_rst    = held;
  assign emu_mode    = (mode == MODE_EMU);
  assign p0_float_en = emu_mode;
  assign weak_pu_en  = emu_mode;

  // R1: everything is quiet right after power-on reset
  p_quiet_after_por_r1: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(arst_n) |-> (!core_rst && !emu_mode));
endmodule

// File: tb/tb_rst_emu_ctrl.sv
module tb_rst_emu_ctrl;
  logic clk = 1'b0;
  logic arst_n, mc_tick, rst_pin, ale_pin, psen_pin;
  logic core_rst, emu_mode, p0_float_en, weak_pu_en;

  int total = 0;
  int bad = 0;
  int tick_cnt = 0;
  bit seen_rst = 0;
  bit done = 0;

  bit sync_q[$];
  int m_cnt;
  bit m_held, m_hprev, m_armed, m_dbg, n_armed, cond;

  always #10 clk = ~clk;

  rst_emu_ctrl dut (
    .clk(clk), .arst_n(arst_n), .mc_tick(mc_tick), .rst_pin(rst_pin),
    .ale_pin(ale_pin), .psen_pin(psen_pin), .core_rst(core_rst),
    .emu_mode(emu_mode), .p0_float_en(p0_float_en), .weak_pu_en(weak_pu_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // machine-cycle tick: one clock in four
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % 4;
    mc_tick <= (tick_cnt == 0);
  end

  // behavioural reference
  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q = {1'b0, 1'b0};
      m_cnt = 0; m_held = 0; m_hprev = 0; m_armed = 0; m_dbg = 0;
    end else begin
      cond = !ale_pin && psen_pin;
      if (!m_held)       n_armed = 0;
      else if (!m_hprev) n_armed = cond;
      else               n_armed = m_armed && cond;
      if (m_hprev && !m_held) m_dbg = m_armed && !ale_pin;
      m_hprev = m_held;
      m_armed = n_armed;
      if (!sync_q[0]) m_cnt = 0;
      else if (mc_tick && m_cnt < 2) m_cnt++;
      m_held = (m_cnt == 2);
      sync_q.push_back(rst_pin);
      void'(sync_q.pop_front());
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (arst_n && !done) begin
      chk("R2 core_rst", core_rst, m_held);
      chk("R5 emu_mode", emu_mode, m_dbg);
      chk("R8 p0_float_en", p0_float_en, m_dbg);
      chk("R8 weak_pu_en", weak_pu_en, m_dbg);
    end
    if (core_rst) seen_rst = 1;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    arst_n = 0; rst_pin = 0; ale_pin = 1; psen_pin = 1; mc_tick = 0;
    cyc(3);
    chk("R1 core_rst", core_rst, 1'b0);
    chk("R1 emu_mode", emu_mode, 1'b0);
    arst_n = 1;
    cyc(2);
    chk("R1 float", p0_float_en, 1'b0);
    chk("R1 pullup", weak_pu_en, 1'b0);

    // R3: short pulses never qualify
    seen_rst = 0;
    rst_pin = 1; cyc(3); rst_pin = 0; cyc(2);
    rst_pin = 1; cyc(3); rst_pin = 0; cyc(10);
    chk("R3 no reset from short pulses", seen_rst, 1'b0);

    // R6: normal reset, address strobe high
    rst_pin = 1; cyc(20);
    chk("R2 reset held", core_rst, 1'b1);
    rst_pin = 0; cyc(4);
    chk("R4 reset released", core_rst, 1'b0);
    cyc(4);
    chk("R6 normal mode", emu_mode, 1'b0);

    // R5: entry pattern held through release
    ale_pin = 0; psen_pin = 1; rst_pin = 1; cyc(20);
    rst_pin = 0; cyc(8);
    chk("R5 entered emulator", emu_mode, 1'b1);
    chk("R8 float in emulator", p0_float_en, 1'b1);

    // R9: strobe activity and short pulses do not leave
    for (int i = 0; i < 6; i++) begin
      ale_pin = i[0]; psen_pin = i[1]; cyc(1);
    end
    rst_pin = 1; cyc(3); rst_pin = 0; cyc(8);
    chk("R9 stays in emulator", emu_mode, 1'b1);

    // R10: mode holds during reset, R9 exit on clean release
    ale_pin = 0; psen_pin = 1; rst_pin = 1; cyc(20);
    chk("R10 mode held in reset", emu_mode, 1'b1);
    ale_pin = 1; cyc(4);
    rst_pin = 0; cyc(8);
    chk("R9 left emulator", emu_mode, 1'b0);

    // R7: fetch strobe glitch during reset blocks entry
    ale_pin = 0; psen_pin = 1; rst_pin = 1; cyc(20);
    psen_pin = 0; cyc(1); psen_pin = 1; cyc(10);
    rst_pin = 0; cyc(8);
    chk("R7 no entry after glitch", emu_mode, 1'b0);

    // R6: pattern held in reset but strobe high before release
    rst_pin = 1; cyc(20);
    ale_pin = 1; cyc(2);
    rst_pin = 0; cyc(8);
    chk("R6 no entry with ale high", emu_mode, 1'b0);

    // R5: clean re-entry
    ale_pin = 0; rst_pin = 1; cyc(16);
    rst_pin = 0; cyc(8);
    chk("R5 re-entry", emu_mode, 1'b1);
    ale_pin = 1; cyc(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule